// File: doc/BRIEF.md
# Sign-Selection Binary Correlator

This block measures how well the most recent stretch of a signed sample stream matches a fixed two-level code of 15 chips. Each chip lasts four samples, so the match is taken over a 60-sample window. Each sample is multiplied only by +1 or −1, so the block uses no multiplier. It adds a stored sample where the chip is +1 and subtracts it where the chip is −1. The result is one signed correlation value per sample period. A downstream threshold or peak search uses that value to find where a known preamble lines up.

All logic runs on one clock. Two enables set the pace: `smp_stb` marks the slow sample period and `work_en` marks the faster work rate. A strobe shifts the new sample into the window and starts a computation. The window is split into four lanes of 15 taps each. Each lane walks its taps one per work-enabled cycle and keeps its own running sum. One more work-enabled cycle adds the four lane sums and presents the total with a single-cycle valid pulse. The code is held in a register. It is set to a parameter value at reset and can be replaced at run time.

Top module: `sscorr_top`

## Requirements
- R1: Each result equals the sum over n = 0..59 of w[n]·c[n/4]. Here w[59] is the newest sample, w[0] is the sample taken 59 strobes earlier, and c[m] is +1 when bit m of the code register is 1 and −1 when it is 0.
- R2: A strobe shifts `smp_in` into the window once. Window positions not yet filled since reset hold zero.
- R3: Results are exact over the full input range. With 60 samples of −2048, an all-ones code gives −122880 and an all-zeros code gives +122880. The output never leaves ±60·2048.
- R4: `corr_vld` is high for exactly one cycle per completed computation. When `work_en` is held high it rises 17 clock edges after the edge that captures the strobe, counting that edge.
- R5: Computation advances only on cycles with `work_en` high. Stalling it delays the result but does not change its value. The valid pulse always follows a work-enabled cycle.
- R6: A strobe that arrives while a computation is pending abandons it. Only the newest window produces a result, and no valid pulse appears in the cycle after any strobe.
- R7: A cycle with `ref_we` high loads `ref_bits` into the code register, with bit m as chip m. Reset loads the parameter `REF_INIT`, which defaults to 15'b011001010111101. Computations started after a load use the new code.
- R8: After reset `corr_out` is 0 and `corr_vld` is 0.
- R9: `corr_out` holds its value except in the cycle in which `corr_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Slow-rate strobe: capture a sample and start a computation |
| smp_in | input | 12 | Signed two's-complement sample |
| work_en | input | 1 | Fast-rate enable that advances the computation |
| ref_we | input | 1 | Load the code register from `ref_bits` |
| ref_bits | input | 15 | New code, bit m = chip m, 1 = +1, 0 = −1 |
| corr_out | output | 18 | Signed correlation result |
| corr_vld | output | 1 | One-cycle pulse when `corr_out` is new |

## Verification
Most internal faults in this block corrupt the number rather than the handshake. A window entry shifted into the wrong place, a lane reading the wrong tap, or a sign taken from the wrong chip each give a result that differs from the dot product on the first strobe whose window is not flat. A scoreboard therefore compares every result with an independent model. A stuck lane counter or a wrong final addition shows up on the first result. A fault in the control sequence shows up as a missing, doubled or mistimed valid pulse within 17 work-enabled cycles of a strobe. Full-scale windows expose any accumulator that is too narrow.

// File: rtl/sscorr_pkg.sv
package sscorr_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACC  = 2'd1,
      PH_SUM  = 2'd2
   } phase_t;
endpackage

// File: rtl/sscorr_window.sv
module sscorr_window #(
   parameter int SW   = 12,
   parameter int TAPS = 60
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           shift,
   input  logic signed [SW-1:0]           din,
   output logic        [TAPS-1:0][SW-1:0] win
);
   // win[TAPS-1] is the newest sample, win[0] the oldest
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win <= '0;
      end else if (shift) begin
         for (int n = 0; n < TAPS - 1; n++) begin
            win[n] <= win[n+1];
         end
         win[TAPS-1] <= din;
      end
   end
endmodule

// File: rtl/sscorr_lane.sv
module sscorr_lane #(
   parameter int SW = 12,
   parameter int AW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic signed [SW-1:0] din,
   input  logic                 chip_pos,
   output logic signed [AW-1:0] acc
);
   logic signed [AW-1:0] din_x;
   assign din_x = AW'(din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (clr) begin
         acc <= '0;
      end else if (en) begin
         acc <= chip_pos ? (acc + din_x) : (acc - din_x);
      end
   end
endmodule

// File: rtl/sscorr_seq.sv
module sscorr_seq
   import sscorr_pkg::*;
#(
   parameter int STEPS = 15,
   localparam int STW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stb,
   input  logic           work_en,
   output logic           clr,
   output logic           acc_en,
   output logic           sum_en,
   output logic [STW-1:0] step
);
   localparam logic [STW-1:0] LAST = STW'(STEPS - 1);

   phase_t phase;

   assign clr    = stb;
   assign acc_en = (phase == PH_ACC) && work_en && !stb;
   assign sum_en = (phase == PH_SUM) && work_en && !stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         step  <= '0;
      end else if (stb) begin
         phase <= PH_ACC;
         step  <= '0;
      end else if (acc_en) begin
         if (step == LAST) begin
            phase <= PH_SUM;
            step  <= '0;
         end else begin
            step <= step + 1'b1;
         end
      end else if (sum_en) begin
         phase <= PH_IDLE;
      end
   end
endmodule

// File: rtl/sscorr_top.sv
module sscorr_top #(
   parameter int               SW       = 12,
   parameter int               CHIPS    = 15,
   parameter int               OSR      = 4,
   parameter int               LANES    = 4,
   parameter logic [CHIPS-1:0] REF_INIT = 15'b011001010111101,
   localparam int              TAPS     = CHIPS * OSR,
   localparam int              STEPS    = TAPS / LANES,
   localparam int              AW       = SW + $clog2(TAPS),
   localparam int              STW      = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_stb,
   input  logic signed [SW-1:0] smp_in,
   input  logic                 work_en,
   input  logic                 ref_we,
   input  logic [CHIPS-1:0]     ref_bits,
   output logic signed [AW-1:0] corr_out,
   output logic                 corr_vld
);
   if (TAPS % LANES != 0) begin : g_bad_split
      $error("sscorr_top: window of %0d taps does not split into %0d lanes", TAPS, LANES);
   end
   if (SW < 2) begin : g_bad_width
      $error("sscorr_top: sample width %0d too small", SW);
   end

   logic [CHIPS-1:0]           ref_q;
   logic [TAPS-1:0][SW-1:0]    win;
   logic                       clr, acc_en, sum_en;
   logic [STW-1:0]             step;
   logic signed [AW-1:0]       lane_acc [LANES];
   logic signed [AW-1:0]       total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= REF_INIT;
      end else if (ref_we) begin
         ref_q <= ref_bits;
      end
   end

   sscorr_window #(.SW(SW), .TAPS(TAPS)) win_i (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (smp_stb),
      .din   (smp_in),
      .win   (win)
   );

   sscorr_seq #(.STEPS(STEPS)) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (smp_stb),
      .work_en (work_en),
      .clr     (clr),
      .acc_en  (acc_en),
      .sum_en  (sum_en),
      .step    (step)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic signed [SW-1:0] tap;
      logic                 chip;
      always_comb begin
         int idx;
         idx  = j * STEPS + int'(step);
         tap  = win[idx];
         chip = ref_q[idx / OSR];
      end
      sscorr_lane #(.SW(SW), .AW(AW)) lane_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .en       (acc_en),
         .din      (tap),
         .chip_pos (chip),
         .acc      (lane_acc[j])
      );
   end

   if (LANES == 1) begin : g_sum_single
      assign total = lane_acc[0];
   end else begin : g_sum_multi
      always_comb begin
         total = '0;
         for (int j = 0; j < LANES; j++) begin
            total = total + lane_acc[j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_out <= '0;
         corr_vld <= 1'b0;
      end else begin
         corr_vld <= sum_en;
         if (sum_en) begin
            corr_out <= total;
         end
      end
   end
endmodule

// File: rtl/sscorr_top_chk.sv
module sscorr_top_chk #(
   parameter int SW    = 12,
   parameter int CHIPS = 15,
   parameter int OSR   = 4,
   parameter int AW    = 18
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_stb,
   input logic                 work_en,
   input logic signed [AW-1:0] corr_out,
   input logic                 corr_vld
);
   localparam longint BOUND = longint'(CHIPS * OSR) * (longint'(1) <<< (SW - 1));

   // R4: valid is a single-cycle pulse
   p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      corr_vld |=> !corr_vld);

   // R5: a result only appears after a work-enabled cycle
   p_vld_after_work_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(corr_vld) |-> $past(work_en));

   // R6: a strobe never lets a result out in the following cycle
   p_stb_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !corr_vld);

   // R9: output only moves together with the valid pulse
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(corr_out) |-> corr_vld);

   // R3: result stays inside the full-scale range
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'(corr_out) <= BOUND) && (longint'(corr_out) >= -BOUND));
endmodule

bind sscorr_top sscorr_top_chk #(
   .SW(SW), .CHIPS(CHIPS), .OSR(OSR), .AW(AW)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_stb  (smp_stb),
   .work_en  (work_en),
   .corr_out (corr_out),
   .corr_vld (corr_vld)
);

// File: tb/sscorr_top_tb_top.sv
`timescale 1ns/1ps
module sscorr_top_tb_top;
   localparam int SW = 12, CHIPS = 15, OSR = 4, TAPS = 60, AW = 18;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 smp_stb = 1'b0;
   logic signed [SW-1:0] smp_in = '0;
   logic                 work_en = 1'b1;
   logic                 ref_we = 1'b0;
   logic [CHIPS-1:0]     ref_bits = '0;
   logic signed [AW-1:0] corr_out;
   logic                 corr_vld;

   always #2 clk = ~clk;

   sscorr_top dut_i (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
      .work_en(work_en), .ref_we(ref_we), .ref_bits(ref_bits),
      .corr_out(corr_out), .corr_vld(corr_vld)
   );

   int checks = 0, fails = 0;
   int cyc = 0;
   int exp_q[$];
   int stb_q[$];
   int last_val = 0;
   bit stall_mode = 1'b0;
   bit done = 1'b0;
   int mw[TAPS];
   logic [CHIPS-1:0] mref = 15'b011001010111101;
   int unsigned seed = 32'h1234_5678;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (stall_mode) work_en <= ~work_en;
      else            work_en <= 1'b1;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: pops expected results as the design produces them (R1, R4, R9)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (corr_vld) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected result", int'(corr_out), 0);
            end else begin
               int e, s;
               e = exp_q.pop_front();
               s = stb_q.pop_front();
               check(int'(corr_out) == e, "R1 correlation value", int'(corr_out), e);
               if (s >= 0) check(cyc - s == 17, "R4 latency", cyc - s, 17);
               last_val = int'(corr_out);
            end
         end else begin
            check(int'(corr_out) == last_val, "R9 hold", int'(corr_out), last_val);
         end
      end
   end

   function automatic int model_dot();
      int sum = 0;
      for (int n = 0; n < TAPS; n++) sum += mref[n / OSR] ? mw[n] : -mw[n];
      return sum;
   endfunction

   // Driver: strobes one sample in and pushes the expected result (R2)
   task automatic push_sample(input int v, input int gap, input bit abort_prev);
      @(negedge clk);
      smp_stb = 1'b1;
      smp_in  = SW'(v);
      for (int n = 0; n < TAPS - 1; n++) mw[n] = mw[n+1];
      mw[TAPS-1] = v;
      if (abort_prev) begin
         exp_q.delete();
         stb_q.delete();
      end
      exp_q.push_back(model_dot());
      stb_q.push_back(stall_mode ? -1 : cyc);
      @(negedge clk);
      smp_stb = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic load_ref(input logic [CHIPS-1:0] code);
      @(negedge clk);
      ref_we = 1'b1;
      ref_bits = code;
      mref = code;
      @(negedge clk);
      ref_we = 1'b0;
   endtask

   function automatic int next_val();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 12) & 32'hFFF) - 2048;
   endfunction

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         check(1'b0, "watchdog", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < TAPS; n++) mw[n] = 0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(corr_out == '0, "R8 reset out", int'(corr_out), 0);
      check(corr_vld == 1'b0, "R8 reset vld", int'(corr_vld), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2: window fills from zero with varied samples, default code (R7 reset value)
      for (int k = 0; k < 70; k++) push_sample(next_val(), 20, 1'b0);

      // R3: full-scale extremes
      load_ref('1);
      for (int k = 0; k < TAPS; k++) push_sample(-2048, 18, 1'b0);
      check(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);
      check(last_val == -122880, "R3 all-ones code", last_val, -122880);
      load_ref('0);
      push_sample(-2048, 20, 1'b0);
      check(last_val == 122880, "R3 all-zeros code", last_val, 122880);
      push_sample(2047, 20, 1'b0);

      // R7: new code at run time
      load_ref(15'b101100111000110);
      for (int k = 0; k < 20; k++) push_sample(next_val(), 20, 1'b0);

      // R5: work enable toggling stalls but keeps values
      stall_mode = 1'b1;
      for (int k = 0; k < 8; k++) push_sample(next_val(), 40, 1'b0);
      stall_mode = 1'b0;
      repeat (4) @(negedge clk);

      // R6: a strobe in mid-computation abandons the previous one
      push_sample(next_val(), 5, 1'b0);
      push_sample(next_val(), 20, 1'b1);
      push_sample(next_val(), 10, 1'b0);
      push_sample(next_val(), 25, 1'b1);

      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R4 every result delivered", exp_q.size(), 0);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule